// File: doc/BRIEF.md
# Low-power wake-up sequencer

This controller takes a chip out of a stop or sleep state in timed steps and then lets the processor leave reset. Software or a power manager first requests entry with a one-cycle pulse. At that moment the block records three things: the power mode (stop or sleep), whether the reference oscillator stays running, and whether the top domain keeps its supply. It then turns off the PLL. In sleep it also turns off the external regulator, and it turns off the oscillator unless that was kept. Finally it holds the processor in reset.

An asynchronous wake input passes through a two-stage synchroniser. It then starts a chain of waits that are counted in reference-oscillator ticks. The chain depends on the mode:

- A regulator-on wait comes first, in sleep only.
- An oscillator settling wait follows, only if the oscillator was stopped.
- If the top domain kept its supply, a PLL lock wait follows and then a short tail.
- If the top domain lost its supply, a long tail follows with no PLL wait. Sleep and stop each have their own tail length.

The clock-supply strobe pulses when the tail begins. The processor reset is released when the tail ends. Every wait length is held in a programmable count register. Its reset default is set by a parameter.

Top module: `wake_seq`

## Requirements
- R1: After reset the block is running: cpu_run, reg_en, osc_en and pll_en are 1; busy, done and clk_strobe are 0.
- R2: An enter_lp pulse while running and idle captures sleep_sel, osc_keep and top_on. From the next cycle until wake: cpu_run=0, pll_en=0, reg_en = not sleep_sel, osc_en = osc_keep, busy=0.
- R3: wake_in is synchronised by two flops. In the low-power state, a wake_in held high raises busy on the third clock edge after it is set.
- R4: In sleep mode, reg_en rises as busy rises, and the regulator wait (count index 0) runs first.
- R5: When the oscillator was stopped (osc_keep=0), osc_en rises when the oscillator wait (index 1) starts. That wait follows the regulator wait, or it starts at wake in stop mode.
- R6: With top_on=1, pll_en rises when the PLL wait (index 2) starts. clk_strobe pulses when the PLL wait ends. A tail then follows: index 4 if the oscillator wait ran, otherwise index 3.
- R7: With top_on=0, pll_en stays 0 throughout and no PLL wait is made. clk_strobe pulses when the tail starts. The tail is index 5 in stop mode and index 6 in sleep mode.
- R8: When the tail ends, cpu_run rises and done pulses for exactly one cycle, in the same cycle that busy falls. clk_strobe pulses exactly once per wake.
- R9: A wait loaded with N ends on the N-th ref_tick counted inside it; N=0 behaves as N=1. The total number of ticks from busy to cpu_run is therefore the sum of the chosen waits.
- R10: cfg_we with cfg_idx 0..6 writes cfg_wdata into that count register. A write to index 7 changes nothing. Before any write, the registers hold the parameter defaults.
- R11: wake_in and enter_lp are ignored while busy, and wake_in is ignored while running: the sequence neither restarts nor changes length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference-oscillator period |
| wake_in | input | 1 | Asynchronous wake event, level |
| enter_lp | input | 1 | Request to enter the low-power state (pulse) |
| sleep_sel | input | 1 | 1 = sleep, 0 = stop; sampled at entry |
| osc_keep | input | 1 | 1 = oscillator stays on in low power; sampled at entry |
| top_on | input | 1 | 1 = top domain retains power; sampled at entry |
| cfg_we | input | 1 | Count register write strobe |
| cfg_idx | input | 3 | Count register index 0..6 |
| cfg_wdata | input | CW | Count value in reference ticks |
| reg_en | output | 1 | External regulator enable |
| osc_enable | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_strobe | output | 1 | One-cycle pulse: processor clock supplied |
| cpu_run | output | 1 | 1 = processor reset released |
| busy | output | 1 | Wake sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
A wrong phase order or a wrong branch choice shows up as an enable that rises at the wrong tick. It can also show up as a clk_strobe at the wrong tick, or as pll_en rising on a path that must leave the PLL off. A miscounting timer moves the rise of cpu_run by whole reference ticks, and the bench detects that at the end of each wake sequence. To do this, the bench counts ticks from busy to every output edge and compares each count with sums worked out from the programmed waits. This is done over all eight combinations of mode, oscillator and top domain. A captured-mode error already appears in the low-power outputs, one cycle after entry.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [2:0] {
    S_RUN, S_LP, S_REG, S_OSC, S_PLL, S_TAIL
  } seq_state_t;

  localparam int unsigned NCFG     = 7;
  localparam int unsigned IW       = 3;
  localparam int unsigned IDX_REG  = 0;
  localparam int unsigned IDX_OSC  = 1;
  localparam int unsigned IDX_PLL  = 2;
  localparam int unsigned IDX_WARM = 3;
  localparam int unsigned IDX_COLD = 4;
  localparam int unsigned IDX_OFF  = 5;
  localparam int unsigned IDX_PWR  = 6;
endpackage

// File: rtl/wake_seq_sync.sv
module wake_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wake_seq_cfg.sv
module wake_seq_cfg
  import wake_seq_pkg::*;
#(
  parameter int CW = 20,
  parameter logic [NCFG*CW-1:0] DEFS = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [CW-1:0]      wdata,
  output logic [NCFG*CW-1:0] vals
);
  for (genvar i = 0; i < NCFG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        vals[i*CW +: CW] <= DEFS[i*CW +: CW];
      else if (we && idx == IW'(i))
        vals[i*CW +: CW] <= wdata;
    end
  end
endmodule

// File: rtl/wake_seq_timer.sv
module wake_seq_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (tick && cnt > CW'(1))  cnt <= cnt - CW'(1);
  end

  // a count of 0 or 1 ends on the next tick
  assign expire = tick && (cnt <= CW'(1));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int CW     = 20,
  parameter int P_REG  = 120000,
  parameter int P_OSC  = 24000,
  parameter int P_PLL  = 7200,
  parameter int P_WARM = 926,
  parameter int P_COLD = 896,
  parameter int P_OFF  = 1688,
  parameter int P_PWR  = 138
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic          wake_in,
  input  logic          enter_lp,
  input  logic          sleep_sel,
  input  logic          osc_keep,
  input  logic          top_on,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [CW-1:0] cfg_wdata,
  output logic          reg_en,
  output logic          osc_enable,
  output logic          pll_en,
  output logic          clk_strobe,
  output logic          cpu_run,
  output logic          busy,
  output logic          done
);
  localparam logic [NCFG*CW-1:0] DEFS = {CW'(P_PWR), CW'(P_OFF), CW'(P_COLD),
    CW'(P_WARM), CW'(P_PLL), CW'(P_OSC), CW'(P_REG)};

  logic               wake_s;
  logic [NCFG*CW-1:0] cvals;
  logic               expire, load;
  logic [CW-1:0]      load_val;
  seq_state_t         state, nxt;
  seq_state_t         after_osc_st, after_reg_st, first_st;
  logic               sleep_q, keep_q, top_q;

  wake_seq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(wake_in), .q(wake_s));

  wake_seq_cfg #(.CW(CW), .DEFS(DEFS)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .vals(cvals));

  wake_seq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .tick(ref_tick), .expire(expire));

  function automatic logic [CW-1:0] cv(input int unsigned i);
    return cvals[i*CW +: CW];
  endfunction

  function automatic logic is_phase(input seq_state_t s);
    return (s == S_REG) || (s == S_OSC) || (s == S_PLL) || (s == S_TAIL);
  endfunction

  // phase chain derived from the mode captured at entry
  assign after_osc_st = top_q  ? S_PLL : S_TAIL;
  assign after_reg_st = keep_q ? after_osc_st : S_OSC;
  assign first_st     = sleep_q ? S_REG : after_reg_st;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    case (state)
      S_RUN:  if (enter_lp) nxt = S_LP;
      S_LP:   if (wake_s) begin nxt = first_st; load = 1'b1; end
      S_REG:  if (expire) begin nxt = after_reg_st; load = 1'b1; end
      S_OSC:  if (expire) begin nxt = after_osc_st; load = 1'b1; end
      S_PLL:  if (expire) begin nxt = S_TAIL; load = 1'b1; end
      S_TAIL: if (expire) nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_comb begin
    case (nxt)
      S_REG:   load_val = cv(IDX_REG);
      S_OSC:   load_val = cv(IDX_OSC);
      S_PLL:   load_val = cv(IDX_PLL);
      S_TAIL:  load_val = top_q ? (keep_q ? cv(IDX_WARM) : cv(IDX_COLD))
                                : (sleep_q ? cv(IDX_PWR) : cv(IDX_OFF));
      default: load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_RUN;
      sleep_q    <= 1'b0;
      keep_q     <= 1'b1;
      top_q      <= 1'b1;
      reg_en     <= 1'b1;
      osc_enable <= 1'b1;
      pll_en     <= 1'b1;
      cpu_run    <= 1'b1;
      clk_strobe <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= nxt;
      busy       <= is_phase(nxt);
      clk_strobe <= (nxt == S_TAIL) && (state != S_TAIL);
      done       <= (state == S_TAIL) && (nxt == S_RUN);
      if (state == S_RUN && nxt == S_LP) begin
        sleep_q    <= sleep_sel;
        keep_q     <= osc_keep;
        top_q      <= top_on;
        reg_en     <= !sleep_sel;
        osc_enable <= osc_keep;
        pll_en     <= 1'b0;
        cpu_run    <= 1'b0;
      end
      if (is_phase(nxt))                      reg_en     <= 1'b1;
      if (nxt == S_OSC)                       osc_enable <= 1'b1;
      if (nxt == S_PLL)                       pll_en     <= 1'b1;
      if (state == S_TAIL && nxt == S_RUN)    cpu_run    <= 1'b1;
    end
  end

  a_r2_lp_holds_reset: assert property (@(posedge clk) disable iff (rst)
    (state == S_LP) |-> (!cpu_run && !pll_en && !busy));
  a_r4_reg_on_later_phases: assert property (@(posedge clk) disable iff (rst)
    (state == S_OSC || state == S_PLL || state == S_TAIL) |-> reg_en);
  a_r6_pll_at_strobe: assert property (@(posedge clk) disable iff (rst)
    (clk_strobe && top_q) |-> pll_en);
  a_r7_pll_off_path: assert property (@(posedge clk) disable iff (rst)
    (busy && !top_q) |-> !pll_en);
  a_r8_release_after_tail: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_run) |-> ($past(state) == S_TAIL && done));
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_busy_no_reentry: assert property (@(posedge clk) disable iff (rst)
    busy |=> (state != S_LP));
endmodule

// File: tb/wake_seq_test.sv
`timescale 1ns/1ps
module wake_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, wake_in = 1'b0, enter_lp = 1'b0;
  logic sleep_sel = 1'b0, osc_keep = 1'b0, top_on = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [19:0] cfg_wdata = '0;
  logic reg_en, osc_enable, pll_en, clk_strobe, cpu_run, busy, done;

  int tests = 0, fails = 0;
  int cur [7];

  always #2.5 clk = ~clk;

  wake_seq #(.CW(20), .P_REG(6), .P_OSC(4), .P_PLL(9), .P_WARM(5),
             .P_COLD(3), .P_OFF(10), .P_PWR(2)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wake_in(wake_in),
    .enter_lp(enter_lp), .sleep_sel(sleep_sel), .osc_keep(osc_keep),
    .top_on(top_on), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .reg_en(reg_en), .osc_enable(osc_enable),
    .pll_en(pll_en), .clk_strobe(clk_strobe), .cpu_run(cpu_run),
    .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = 20'(val);
    if (idx < 7) cur[idx] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_seq(input bit slp, input bit keep, input bit top,
                         input bit disturb, input string tag);
    int n, k, ticks, reg_t, osc_t, pll_t, str_t, str_n, done_n;
    int r, o, p, tl, e_str, e_tot;
    bit p_reg, p_osc, p_pll, to;
    @(negedge clk);
    sleep_sel = slp; osc_keep = keep; top_on = top; enter_lp = 1'b1;
    @(negedge clk);
    enter_lp = 1'b0;
    check(cpu_run == 0 && pll_en == 0 && busy == 0, {"R2 hold ", tag}, cpu_run, 0);
    check(reg_en == !slp && osc_enable == keep, {"R2 enables ", tag},
          {reg_en, osc_enable}, {!slp, keep});
    wake_in = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!busy && n < 10);
    check(n == 3, {"R3 sync latency ", tag}, n, 3);
    wake_in = 1'b0;
    r = slp ? eff(cur[0]) : 0;
    o = keep ? 0 : eff(cur[1]);
    p = top ? eff(cur[2]) : 0;
    tl = top ? (keep ? eff(cur[3]) : eff(cur[4])) : (slp ? eff(cur[6]) : eff(cur[5]));
    e_str = r + o + p;
    e_tot = e_str + tl;
    ticks = 0; k = 0; reg_t = -1; osc_t = -1; pll_t = -1; str_t = -1;
    str_n = 0; done_n = 0; to = 0;
    p_reg = !slp; p_osc = keep; p_pll = 0;
    forever begin
      if (reg_en && !p_reg) reg_t = ticks;
      if (osc_enable && !p_osc) osc_t = ticks;
      if (pll_en && !p_pll) pll_t = ticks;
      if (clk_strobe) begin str_n++; str_t = ticks; end
      if (done) done_n++;
      p_reg = reg_en; p_osc = osc_enable; p_pll = pll_en;
      if (cpu_run) break;
      if (k > 5000) begin to = 1; break; end
      ref_tick = (k % 3 == 0);
      if (ref_tick) ticks++;
      if (disturb && k == 4) begin wake_in = 1'b1; enter_lp = 1'b1; end
      if (disturb && k == 5) enter_lp = 1'b0;
      if (disturb && k == 12) wake_in = 1'b0;
      k++;
      @(negedge clk);
    end
    ref_tick = 1'b0; wake_in = 1'b0; enter_lp = 1'b0;
    check(!to, {"R8 watchdog ", tag}, k, 0);
    check(ticks == e_tot, {"R9 total ticks ", tag}, ticks, e_tot);
    check(str_n == 1 && str_t == e_str, {"R8 strobe ", tag}, str_t, e_str);
    check(done_n == 1 && busy == 0, {"R8 done ", tag}, done_n, 1);
    if (slp) check(reg_t == 0, {"R4 regulator first ", tag}, reg_t, 0);
    if (!keep) check(osc_t == r, {"R5 osc start ", tag}, osc_t, r);
    if (top) check(pll_t == r + o, {"R6 pll start ", tag}, pll_t, r + o);
    else     check(pll_t == -1 && pll_en == 0, {"R7 pll stays off ", tag}, pll_t, -1);
    if (disturb) check(ticks == e_tot, {"R11 ignored while busy ", tag}, ticks, e_tot);
    repeat (6) @(negedge clk);
    check(busy == 0 && cpu_run == 1, {"R11 no restart ", tag}, busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    cur = '{6, 4, 9, 5, 3, 10, 2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_run && reg_en && osc_enable && pll_en, "R1 enables after reset",
          {cpu_run, reg_en, osc_enable, pll_en}, 15);
    check(!busy && !done && !clk_strobe, "R1 status after reset",
          {busy, done, clk_strobe}, 0);
    wake_in = 1'b1;
    repeat (10) @(negedge clk);
    wake_in = 1'b0;
    check(busy == 0 && cpu_run == 1, "R11 wake while running", busy, 0);
    run_seq(1, 0, 1, 0, "R10 defaults sleep/cold/top");
    run_seq(0, 1, 0, 0, "R10 defaults stop/warm/off");
    wr(0, 5); wr(1, 7); wr(2, 11); wr(3, 3); wr(4, 2); wr(5, 13); wr(6, 4);
    wr(7, 1);
    for (int m = 0; m < 8; m++)
      run_seq(m[2], m[1], m[0], m == 5, $sformatf("R10 sweep m%0d", m));
    wr(0, 0); wr(2, 0); wr(3, 0);
    run_seq(1, 0, 1, 0, "R9 zero counts a");
    run_seq(0, 1, 1, 1, "R9 zero counts b");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule